// File: doc/BRIEF.md
# SCSI Bus Phase Transfer Sequencer

This block moves a SCSI initiator through its bus phases while a host pushes or pulls bytes one at a time through a data register. The host loads a 24-bit byte count, a phase code and a command byte through a small register port. Each accepted data write stores the byte in a 12-entry outbound FIFO and counts down. Each accepted data read takes a byte from the target and counts down. The phase changes when the count reaches zero, and the result is posted as a status code with an interrupt.

At terminal count the action depends on the current phase. In message-out the first FIFO byte is kept as the identify byte. In command phase the FIFO is handed to the target, which answers with the next phase and a new count. In data-out the FIFO is handed to the target and the bus moves to status. On the read side, one read in status phase ends in message-in, and a read in message-in with nothing left posts a disconnect. A flag in a stage register can suppress the status step at the end of a read. The target is a request/acknowledge port, and a terminal-count action waits for as long as the target takes to acknowledge.

Top module: `scsi_phase_seq`

Register addresses with the default 24-bit count:

| Address | Register |
|---|---|
| 0 | count bits 23:16 |
| 1 | count bits 15:8 |
| 2 | count bits 7:0 |
| 3 | command |
| 4 | data |
| 5 | status |
| 6 | phase, bits 2:0 |
| 7 | stage |

Phase codes are data-out 0, data-in 1, command 2, status 3, message-out 6 and message-in 7. Register reads are returned on `host_rdata` one cycle after `host_rd`. The host never asserts `host_rd` and `host_wr` in the same cycle.

## Requirements
- R1: After reset the count, phase, stage, command and status are 0, and `irq`, `dbr`, `busy` and `tgt_req` are low.
- R2: The count is read and written one byte at a time at addresses 0 (bits 23:16), 1 (bits 15:8) and 2 (bits 7:0). A count byte write sets `dbr` when the resulting count is nonzero and clears it otherwise.
- R3: A data write (address 4) with a nonzero count appends the byte to the 12-entry FIFO and lowers the count by one. A byte that arrives with the FIFO full is dropped, but it still counts. A data write with count 0 and command bit 7 clear changes nothing.
- R4: When command bit 7 is set, a data write is taken as if the count were 1. The count becomes 0 and the terminal-count action runs. Any write that ends a count clears `dbr`.
- R5: At terminal count in message-out (6), `identify` takes FIFO byte 0. The phase becomes command (2), status 0x1A is posted, and `irq` is set.
- R6: At terminal count in command phase (2), `tgt_req` rises with `tgt_is_cmd`=1, `tgt_len` = number of FIFO bytes, and FIFO byte k in `tgt_bytes[8k+7:8k]`. It holds until `tgt_ack`. On the acknowledge, the count is loaded from `tgt_xfer_count`, the phase becomes `tgt_next_phase`, status 0x18|phase is posted, `irq` is set, and `dbr` reflects a nonzero count.
- R7: At terminal count in data-out (0), the FIFO is handed over the same way with `tgt_is_cmd`=0. On the acknowledge the phase becomes status (3) and status 0x1B is posted.
- R8: A data read with count above 0 (outside the R10 and R11 cases) returns `tgt_rd_byte` and pulses `tgt_rd_pop` when `tgt_rd_valid` is high, and returns 0 otherwise. Either way it lowers the count by one and clears `irq`.
- R9: A data read that lowers the count to 0 clears `dbr` and sets `irq`. If the stage register is not 0x60, it also moves to status (3) and posts 0x1B. With stage 0x60, the phase and status are left unchanged.
- R10: A data read in status phase with count 1 zeroes the count, moves to message-in (7), and posts 0x1F with `irq`.
- R11: A data read in message-in with count 0 posts disconnect status 0x85 with `irq`.
- R12: Reading the status register returns the posted code and clears `irq`.
- R13: While `busy` (waiting on the target), all host writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 3 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid the cycle after host_rd |
| irq | output | 1 | Interrupt pending |
| dbr | output | 1 | Data buffer ready |
| busy | output | 1 | Waiting for target acknowledge |
| identify | output | 8 | Captured identify byte |
| tgt_req | output | 1 | Hand-off request to the target |
| tgt_is_cmd | output | 1 | 1 = command bytes, 0 = data-out bytes |
| tgt_len | output | 4 | Number of valid bytes in tgt_bytes |
| tgt_bytes | output | 96 | FIFO contents, byte k at bits 8k+7:8k |
| tgt_ack | input | 1 | Target accepts the hand-off |
| tgt_next_phase | input | 3 | Phase reported by target on command ack |
| tgt_xfer_count | input | 24 | Byte count reported by target on command ack |
| tgt_rd_valid | input | 1 | Target has an inbound byte |
| tgt_rd_byte | input | 8 | Inbound byte |
| tgt_rd_pop | output | 1 | Inbound byte consumed |

## Verification
The hardest state to reach is a command hand-off where the FIFO has overflowed and the target is late. In that state the length must stop at 12 while the count still runs to zero, and the phase must stay frozen across a stall of several cycles. The bench loads a count of 14 in command phase and writes 14 bytes. It then holds off the acknowledge while it tries register writes, checks that they are ignored, and only then acknowledges with a new phase and count. That acknowledge feeds the following data-in scenario, so the count loaded from the target is what drives the read-side endings.

// File: rtl/scsi_seq_pkg.sv
// Shared codes for the SCSI phase sequencer.
// Assumes 3-bit phase codes as carried on the SCSI control lines.
package scsi_seq_pkg;
    localparam logic [2:0] PH_DOUT = 3'd0;
    localparam logic [2:0] PH_DIN  = 3'd1;
    localparam logic [2:0] PH_CMD  = 3'd2;
    localparam logic [2:0] PH_STAT = 3'd3;
    localparam logic [2:0] PH_MOUT = 3'd6;
    localparam logic [2:0] PH_MIN  = 3'd7;

    localparam logic [7:0] ST_DONE_BASE = 8'h18;
    localparam logic [7:0] ST_DISCONN   = 8'h85;
    localparam logic [7:0] STAGE_NOSTAT = 8'h60;

    // Completion code for a finished transfer in the given phase.
    function automatic logic [7:0] done_code(input logic [2:0] ph);
        return ST_DONE_BASE | {5'b0, ph};
    endfunction
endpackage

// File: rtl/scsi_seq_fifo.sv
// Outbound byte FIFO. Write-only from the host side; the whole content is
// presented flat to the target. A push when full is dropped. Clear wins
// over push. Assumes the consumer reads the flat image, never pops singly.
module scsi_seq_fifo #(
    parameter int DEPTH = 12,
    parameter int W     = 8,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push,
    input  logic [W-1:0]         din,
    input  logic                 clr,
    output logic [LVL_W-1:0]     level,
    output logic                 full,
    output logic [DEPTH*W-1:0]   flat
);
    assign full = (level == LVL_W'(DEPTH));

    // Level tracking: clear resets, push grows when room is left.
    always_ff @(posedge clk) begin
        if (!rst_n)              level <= '0;
        else if (clr)            level <= '0;
        else if (push && !full)  level <= level + LVL_W'(1);
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [W-1:0] ent;
        // Entry store: captures the byte when it is the next free slot.
        always_ff @(posedge clk) begin
            if (!rst_n)                                   ent <= '0;
            else if (push && !full && level == LVL_W'(i)) ent <= din;
        end
        assign flat[i*W +: W] = ent;
    end

    // A dropped push must leave the fill level untouched (R3).
    assert_drop_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !clr) |=> (level == LVL_W'(DEPTH)));
endmodule

// File: rtl/scsi_seq_count.sv
// Transfer byte counter, written and read in byte lanes by the host,
// bulk-loaded by the target, decremented by transfers, cleared by
// single-byte mode. Priority: clear, load, decrement, lane writes.
// Assumes CNT_W is a multiple of 8.
module scsi_seq_count #(
    parameter int CNT_W = 24,
    localparam int NB = CNT_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NB-1:0]     lane_we,
    input  logic [7:0]        lane_data,
    input  logic              load_en,
    input  logic [CNT_W-1:0]  load_val,
    input  logic              dec_en,
    input  logic              clr_en,
    output logic [CNT_W-1:0]  value,
    output logic              is_zero,
    output logic              is_one
);
    logic [CNT_W-1:0] nxt;

    assign is_zero = (value == '0);
    assign is_one  = (value == CNT_W'(1));

    // Next-count selection by operation priority.
    always_comb begin
        nxt = value;
        for (int i = 0; i < NB; i++) begin
            if (lane_we[i]) nxt[i*8 +: 8] = lane_data;
        end
        if (dec_en)  nxt = value - CNT_W'(1);
        if (load_en) nxt = load_val;
        if (clr_en)  nxt = '0;
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) value <= '0;
        else        value <= nxt;
    end

    // The counter never wraps below zero (R3, R8).
    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && !load_en && !clr_en) |-> !is_zero);
endmodule

// File: rtl/scsi_phase_seq.sv
// SCSI phase transfer sequencer top. Host register port drives a byte
// counter and an outbound FIFO; terminal count triggers a phase-specific
// action and posts a completion code with an interrupt. Hand-offs to the
// target stall in a busy state until acknowledged. Assumes host_rd and
// host_wr are never asserted together.
module scsi_phase_seq
    import scsi_seq_pkg::*;
#(
    parameter int CNT_W      = 24,
    parameter int FIFO_DEPTH = 12,
    localparam int NB     = CNT_W / 8,
    localparam int LVL_W  = $clog2(FIFO_DEPTH + 1),
    localparam int ADDR_W = $clog2(NB + 5)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    host_wr,
    input  logic                    host_rd,
    input  logic [ADDR_W-1:0]       host_addr,
    input  logic [7:0]              host_wdata,
    output logic [7:0]              host_rdata,
    output logic                    irq,
    output logic                    dbr,
    output logic                    busy,
    output logic [7:0]              identify,
    output logic                    tgt_req,
    output logic                    tgt_is_cmd,
    output logic [LVL_W-1:0]        tgt_len,
    output logic [FIFO_DEPTH*8-1:0] tgt_bytes,
    input  logic                    tgt_ack,
    input  logic [2:0]              tgt_next_phase,
    input  logic [CNT_W-1:0]        tgt_xfer_count,
    input  logic                    tgt_rd_valid,
    input  logic [7:0]              tgt_rd_byte,
    output logic                    tgt_rd_pop
);
    localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(NB);
    localparam logic [ADDR_W-1:0] A_DATA   = ADDR_W'(NB + 1);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(NB + 2);
    localparam logic [ADDR_W-1:0] A_PHASE  = ADDR_W'(NB + 3);
    localparam logic [ADDR_W-1:0] A_STAGE  = ADDR_W'(NB + 4);

    logic [2:0]       phase_q;
    logic [7:0]       cmd_q, status_q, stage_q, ident_q, rdata_q;
    logic             irq_q, dbr_q, busy_q, busy_cmd_q;

    logic [CNT_W-1:0] cnt;
    logic             cnt_zero, cnt_one;
    logic [NB-1:0]    lane_we;
    logic [CNT_W-1:0] cnt_lane_new;
    logic [7:0]       cnt_rd_byte;
    logic             cnt_rd_hit;

    logic [LVL_W-1:0] fifo_level;
    logic             fifo_full;
    logic [FIFO_DEPTH*8-1:0] fifo_flat;

    // Decoded host events.
    logic data_wr, wr_take, wr_last;
    logic data_rd, rd_disc, rd_stat, rd_take, rd_last;
    logic ack_take, fifo_clr;

    assign data_wr = host_wr && !busy_q && host_addr == A_DATA;
    assign wr_take = data_wr && (cmd_q[7] || !cnt_zero);
    assign wr_last = wr_take && (cmd_q[7] || cnt_one);

    assign data_rd = host_rd && !busy_q && host_addr == A_DATA;
    assign rd_disc = data_rd && phase_q == PH_MIN && cnt_zero;
    assign rd_stat = data_rd && phase_q == PH_STAT && cnt_one;
    assign rd_take = data_rd && !rd_disc && !rd_stat && !cnt_zero;
    assign rd_last = rd_take && cnt_one;

    assign ack_take = busy_q && tgt_ack;
    assign fifo_clr = (wr_last && phase_q == PH_MOUT) || ack_take;

    for (genvar i = 0; i < NB; i++) begin : g_lane
        assign lane_we[i] = host_wr && !busy_q && host_addr == ADDR_W'(NB - 1 - i);
    end

    // Count image after a host lane write, used for the ready flag.
    always_comb begin
        cnt_lane_new = cnt;
        for (int i = 0; i < NB; i++) begin
            if (lane_we[i]) cnt_lane_new[i*8 +: 8] = host_wdata;
        end
    end

    // Count lane readback selection.
    always_comb begin
        cnt_rd_byte = 8'h00;
        cnt_rd_hit  = 1'b0;
        for (int i = 0; i < NB; i++) begin
            if (host_addr == ADDR_W'(NB - 1 - i)) begin
                cnt_rd_byte = cnt[i*8 +: 8];
                cnt_rd_hit  = 1'b1;
            end
        end
    end

    scsi_seq_count #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .lane_we   (lane_we),
        .lane_data (host_wdata),
        .load_en   (ack_take && busy_cmd_q),
        .load_val  (tgt_xfer_count),
        .dec_en    ((wr_take && !cmd_q[7]) || rd_take),
        .clr_en    ((wr_take && cmd_q[7]) || rd_stat),
        .value     (cnt),
        .is_zero   (cnt_zero),
        .is_one    (cnt_one)
    );

    scsi_seq_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (wr_take),
        .din   (host_wdata),
        .clr   (fifo_clr),
        .level (fifo_level),
        .full  (fifo_full),
        .flat  (fifo_flat)
    );

    // Main control: register writes, terminal actions, reads and completions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_DOUT;
            cmd_q      <= '0;
            status_q   <= '0;
            stage_q    <= '0;
            ident_q    <= '0;
            rdata_q    <= '0;
            irq_q      <= 1'b0;
            dbr_q      <= 1'b0;
            busy_q     <= 1'b0;
            busy_cmd_q <= 1'b0;
        end else begin
            if (host_wr && !busy_q) begin
                if (|lane_we)             dbr_q   <= |cnt_lane_new;
                if (host_addr == A_CMD)   cmd_q   <= host_wdata;
                if (host_addr == A_PHASE) phase_q <= host_wdata[2:0];
                if (host_addr == A_STAGE) stage_q <= host_wdata;
            end

            if (wr_last) begin
                dbr_q <= 1'b0;
                case (phase_q)
                    PH_MOUT: begin
                        ident_q  <= (fifo_level == '0) ? host_wdata : fifo_flat[7:0];
                        phase_q  <= PH_CMD;
                        status_q <= done_code(PH_CMD);
                        irq_q    <= 1'b1;
                    end
                    PH_CMD: begin
                        busy_q     <= 1'b1;
                        busy_cmd_q <= 1'b1;
                    end
                    PH_DOUT: begin
                        busy_q     <= 1'b1;
                        busy_cmd_q <= 1'b0;
                    end
                    default: begin
                        status_q <= done_code(phase_q);
                        irq_q    <= 1'b1;
                    end
                endcase
            end

            if (host_rd) begin
                if (cnt_rd_hit) rdata_q <= cnt_rd_byte;
                case (host_addr)
                    A_CMD:    rdata_q <= cmd_q;
                    A_DATA:   rdata_q <= (rd_take && tgt_rd_valid) ? tgt_rd_byte : 8'h00;
                    A_STATUS: begin
                        rdata_q <= status_q;
                        irq_q   <= 1'b0;
                    end
                    A_PHASE:  rdata_q <= {5'b0, phase_q};
                    A_STAGE:  rdata_q <= stage_q;
                    default:  ;
                endcase
            end

            if (rd_disc) begin
                status_q <= ST_DISCONN;
                irq_q    <= 1'b1;
            end
            if (rd_stat) begin
                phase_q  <= PH_MIN;
                status_q <= done_code(PH_MIN);
                irq_q    <= 1'b1;
            end
            if (rd_take) begin
                irq_q <= 1'b0;
                if (rd_last) begin
                    irq_q <= 1'b1;
                    dbr_q <= 1'b0;
                    if (stage_q != STAGE_NOSTAT) begin
                        phase_q  <= PH_STAT;
                        status_q <= done_code(PH_STAT);
                    end
                end
            end

            if (ack_take) begin
                busy_q <= 1'b0;
                irq_q  <= 1'b1;
                if (busy_cmd_q) begin
                    phase_q  <= tgt_next_phase;
                    status_q <= done_code(tgt_next_phase);
                    dbr_q    <= |tgt_xfer_count;
                end else begin
                    phase_q  <= PH_STAT;
                    status_q <= done_code(PH_STAT);
                    dbr_q    <= 1'b0;
                end
            end
        end
    end

    assign host_rdata = rdata_q;
    assign irq        = irq_q;
    assign dbr        = dbr_q;
    assign busy       = busy_q;
    assign identify   = ident_q;
    assign tgt_req    = busy_q;
    assign tgt_is_cmd = busy_cmd_q;
    assign tgt_len    = fifo_level;
    assign tgt_bytes  = fifo_flat;
    assign tgt_rd_pop = rd_take && tgt_rd_valid;

    // A hand-off request stays up until the target accepts it.
    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_req && !tgt_ack) |=> tgt_req);
    // The phase cannot move while a hand-off is pending.
    assert_phase_frozen_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !tgt_ack) |=> $stable(phase_q));
    // Any write that ends the count drops the buffer-ready flag.
    assert_dbr_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_last |=> !dbr_q);
    // A status read leaves no interrupt pending.
    assert_status_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == A_STATUS && !busy_q) |=> !irq_q);
    // Popping the target requires a byte to be offered.
    assert_pop_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_rd_pop |-> tgt_rd_valid);
endmodule

// File: tb/sim_scsi_phase_seq.sv
`timescale 1ns/1ps
module sim_scsi_phase_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        irq, dbr, busy;
    logic [7:0]  identify;
    logic        tgt_req, tgt_is_cmd;
    logic [3:0]  tgt_len;
    logic [95:0] tgt_bytes;
    logic        tgt_ack = 1'b0;
    logic [2:0]  tgt_next_phase = '0;
    logic [23:0] tgt_xfer_count = '0;
    logic        tgt_rd_valid = 1'b0;
    logic [7:0]  tgt_rd_byte = '0;
    logic        tgt_rd_pop;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    scsi_phase_seq u0 (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = 3'(a); host_wdata = 8'(d);
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int d, output int popped);
        @(negedge clk);
        host_rd = 1'b1; host_addr = 3'(a);
        #1 popped = int'(tgt_rd_pop);
        @(negedge clk);
        host_rd = 1'b0;
        d = int'(host_rdata);
    endtask

    task automatic rd_reg(input int a, output int d);
        int p;
        rd(a, d, p);
    endtask

    task automatic set_count(input int c);
        wr(0, (c >> 16) & 255); wr(1, (c >> 8) & 255); wr(2, c & 255);
    endtask

    task automatic get_count(output int c);
        int h, m, l;
        rd_reg(0, h); rd_reg(1, m); rd_reg(2, l);
        c = (h << 16) | (m << 8) | l;
    endtask

    task automatic ack(input int ph, input int cnt);
        @(negedge clk);
        tgt_ack = 1'b1; tgt_next_phase = 3'(ph); tgt_xfer_count = 24'(cnt);
        @(negedge clk);
        tgt_ack = 1'b0;
    endtask

    task automatic t_reset();
        int v;
        chk("R1 irq", int'(irq), 0); chk("R1 dbr", int'(dbr), 0);
        chk("R1 busy", int'(busy), 0); chk("R1 req", int'(tgt_req), 0);
        get_count(v); chk("R1 count", v, 0);
        rd_reg(6, v); chk("R1 phase", v, 0);
        rd_reg(5, v); chk("R1 status", v, 0);
        rd_reg(7, v); chk("R1 stage", v, 0);
    endtask

    task automatic t_count_regs();
        int v;
        set_count(24'h123456);
        get_count(v); chk("R2 count readback", v, 24'h123456);
        chk("R2 dbr set", int'(dbr), 1);
        set_count(0);
        chk("R2 dbr clear", int'(dbr), 0);
    endtask

    task automatic t_ignored_write();
        int v;
        wr(3, 0); wr(6, 0);
        wr(4, 8'h77);
        chk("R3 no req", int'(tgt_req), 0);
        chk("R3 no irq", int'(irq), 0);
        get_count(v); chk("R3 count stays 0", v, 0);
        rd_reg(6, v); chk("R3 phase unchanged", v, 0);
    endtask

    task automatic t_msgout();
        int v;
        wr(6, 6); set_count(1);
        wr(4, 8'hC0);
        chk("R5 identify", int'(identify), 8'hC0);
        chk("R5 irq", int'(irq), 1);
        chk("R4 dbr low", int'(dbr), 0);
        rd_reg(6, v); chk("R5 phase cmd", v, 2);
        rd_reg(5, v); chk("R12 status 1A", v, 8'h1A);
        chk("R12 irq cleared", int'(irq), 0);
    endtask

    task automatic t_cmd_overflow();
        int v;
        wr(6, 2); set_count(14);
        for (int i = 0; i < 14; i++) wr(4, 8'h10 + i);
        chk("R6 req", int'(tgt_req), 1);
        chk("R6 is_cmd", int'(tgt_is_cmd), 1);
        chk("R3 len capped", int'(tgt_len), 12);
        for (int i = 0; i < 12; i++) chk("R6 byte", int'(tgt_bytes[8*i +: 8]), 8'h10 + i);
        get_count(v); chk("R3 count zero", v, 0);
        wr(6, 5); wr(2, 9);
        repeat (3) @(negedge clk);
        chk("R6 req held", int'(tgt_req), 1);
        rd_reg(6, v); chk("R13 phase write ignored", v, 2);
        get_count(v); chk("R13 count write ignored", v, 0);
        ack(1, 3);
        chk("R6 req drop", int'(tgt_req), 0);
        chk("R6 irq", int'(irq), 1);
        chk("R6 dbr", int'(dbr), 1);
        rd_reg(6, v); chk("R6 phase from target", v, 1);
        get_count(v); chk("R6 count loaded", v, 3);
        rd_reg(5, v); chk("R6 status 19", v, 8'h19);
    endtask

    task automatic t_data_in();
        int v, p;
        tgt_rd_valid = 1'b1; tgt_rd_byte = 8'hA1;
        rd(4, v, p); chk("R8 byte", v, 8'hA1); chk("R8 pop", p, 1);
        chk("R8 irq clear", int'(irq), 0);
        tgt_rd_valid = 1'b0;
        rd(4, v, p); chk("R8 empty reads 0", v, 0); chk("R8 no pop", p, 0);
        get_count(v); chk("R8 count dec", v, 1);
        tgt_rd_valid = 1'b1; tgt_rd_byte = 8'hA3;
        rd(4, v, p); chk("R9 last byte", v, 8'hA3);
        tgt_rd_valid = 1'b0;
        chk("R9 irq", int'(irq), 1); chk("R9 dbr", int'(dbr), 0);
        rd_reg(6, v); chk("R9 phase status", v, 3);
        rd_reg(5, v); chk("R9 status 1B", v, 8'h1B);
    endtask

    task automatic t_status_end();
        int v, p;
        set_count(1);
        rd(4, v, p);
        get_count(v); chk("R10 count zero", v, 0);
        rd_reg(6, v); chk("R10 phase msg-in", v, 7);
        chk("R10 irq", int'(irq), 1);
        rd_reg(5, v); chk("R10 status 1F", v, 8'h1F);
        rd(4, v, p);
        chk("R11 irq", int'(irq), 1);
        rd_reg(5, v); chk("R11 status 85", v, 8'h85);
    endtask

    task automatic t_stage60();
        int v, p;
        wr(6, 1); wr(7, 8'h60); set_count(1);
        rd(4, v, p);
        chk("R9 stage irq", int'(irq), 1);
        chk("R9 stage dbr", int'(dbr), 0);
        rd_reg(6, v); chk("R9 stage phase kept", v, 1);
        rd_reg(5, v); chk("R9 stage status kept", v, 8'h85);
        wr(7, 0);
    endtask

    task automatic t_single_byte();
        int v;
        wr(6, 0); set_count(5); wr(3, 8'h80);
        wr(4, 8'h5A);
        chk("R4 req", int'(tgt_req), 1);
        chk("R7 is data", int'(tgt_is_cmd), 0);
        chk("R7 len", int'(tgt_len), 1);
        chk("R7 byte", int'(tgt_bytes[7:0]), 8'h5A);
        ack(2, 0);
        get_count(v); chk("R4 count cleared", v, 0);
        rd_reg(6, v); chk("R7 phase status", v, 3);
        rd_reg(5, v); chk("R7 status 1B", v, 8'h1B);
        wr(3, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count_regs();
        t_ignored_write();
        t_msgout();
        t_cmd_overflow();
        t_data_in();
        t_status_end();
        t_stage60();
        t_single_byte();
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule